// File: doc/BRIEF.md
# Flat Panel Power Sequencer

This block drives the five enable lines of a flat-panel display: the display-period (timing) enable, the logic supply rail, the pixel data link, the bias supply rail and the backlight. In its hardware-sequenced mode it turns them on one at a time in a fixed order when a single power request level goes high. When the request goes low it turns them off in the mirror order. The wait between two steps is a parameter counted in millisecond ticks. A prescaler divides the system clock down to those ticks, and it is restarted each time a step completes, so every wait is an exact number of clock cycles.

A second, direct mode bypasses the sequencer. Each enable then follows its own bit of a five-bit input, with no timing applied. When the block leaves direct mode, the sequencer restarts from fully off. Two status outputs report that the panel is fully on (backlight enabled) and fully off (display period disabled).

Top module: `fps_power_seq`

## Requirements
- R1: During and after synchronous reset, all five enables are low, `off_done` is 1 and `on_done` is 0.
- R2: In hardware mode, the enables always form an ordered prefix of period, supply, data, bias, backlight: an enable is never high unless every enable before it in that order is high. Each step changes exactly one enable.
- R3: In hardware mode with `pwr_req` high, the period enable rises one cycle after the request is sampled. The supply, data, bias and backlight enables then follow with gaps of `DLY_P2V*DIV+1`, `DLY_V2D*DIV+1`, `DLY_D2E*DIV+1` and `DLY_E2B*DIV+1` cycles. DIV is the number of clock cycles per tick.
- R4: In hardware mode with `pwr_req` low, starting from fully on, the backlight falls one cycle after the request is sampled. Bias, data and supply then fall with gaps of `DLY_E2B*DIV+1`, `DLY_D2E*DIV+1` and `DLY_V2D*DIV+1` cycles, and the period enable falls one cycle after the supply.
- R5: A delay parameter of zero makes its step take exactly one cycle.
- R6: A step is taken only after the sequencer has held its present level for the wait that belongs to the currently requested direction, counted from the cycle it arrived. A reversal of `pwr_req` in the middle of a wait therefore moves one step back after that wait; no level is skipped.
- R7: `on_done` equals the registered backlight enable and `off_done` equals the inverse of the registered period enable. In hardware mode the two are never high together.
- R8: With `direct_mode` high, bit i of `direct_en` sets the enable one cycle later (bit 0 period, 1 supply, 2 data, 3 bias, 4 backlight), and `pwr_req` has no effect on any output.
- R9: On the first cycle after `direct_mode` falls, only the period enable may be high. The sequencer then restarts from fully off with fresh wait counts.
- R10: One tick is `DIV = CLK_HZ/TICK_HZ` clock cycles. The tick prescaler and the wait counter restart on every step, so no partial tick is carried from one step to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_req | input | 1 | Power request level: 1 sequences up, 0 sequences down |
| direct_mode | input | 1 | 1 selects direct control of each enable |
| direct_en | input | 5 | Direct-mode enable bits (0 period, 1 supply, 2 data, 3 bias, 4 backlight) |
| period_en | output | 1 | Display-period enable |
| vdd_en | output | 1 | Logic supply rail enable |
| data_en | output | 1 | Pixel data link enable |
| vee_en | output | 1 | Bias supply rail enable |
| backlight_en | output | 1 | Backlight enable |
| on_done | output | 1 | Panel fully on |
| off_done | output | 1 | Panel fully off |

## Verification
The bench builds the block with `CLK_HZ=4000` and `TICK_HZ=1000`, so one tick is four cycles. The step delays are 3, 1, 0 and 2 ticks, so every gap in the sequence has a distinct, short length and the zero-delay step is present. With these values the bench can sweep a reversal at every intermediate level, in both directions, and measure each resulting gap against the arithmetic formula. It can also walk all 32 direct-mode bit patterns and check the return from direct mode.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int unsigned RAIL_CNT = 5;
  localparam int unsigned LVL_W    = 3;

  // Rail positions in the enable vector; the order is the power-up order.
  localparam int unsigned RAIL_PERIOD = 0;
  localparam int unsigned RAIL_VDD    = 1;
  localparam int unsigned RAIL_DATA   = 2;
  localparam int unsigned RAIL_VEE    = 3;
  localparam int unsigned RAIL_BLIGHT = 4;

  // Level = number of rails currently enabled in sequence order.
  typedef logic [LVL_W-1:0] level_t;
  localparam level_t LV_OFF    = 3'd0;
  localparam level_t LV_PERIOD = 3'd1;
  localparam level_t LV_VDD    = 3'd2;
  localparam level_t LV_DATA   = 3'd3;
  localparam level_t LV_VEE    = 3'd4;
  localparam level_t LV_FULL   = 3'd5;
endpackage

// File: rtl/fps_tick_gen.sv
module fps_tick_gen #(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned TICK_HZ = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int unsigned DIV = (CLK_HZ / TICK_HZ < 1) ? 1 : CLK_HZ / TICK_HZ;
  localparam int unsigned CW  = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  generate
    if (DIV > 1) begin : g_chk
      // R10: a restart begins a full tick period, so no tick directly after it
      assert_no_early_tick_R10: assert property (@(posedge clk) disable iff (rst)
        restart |=> !tick)
        else $error("tick too soon after restart");
    end
  endgenerate
endmodule

// File: rtl/fps_dwell_timer.sv
module fps_dwell_timer #(
  parameter int unsigned MAX_TICKS = 200,
  parameter int unsigned EW        = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          tick,
  output logic [EW-1:0] elapsed
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      elapsed <= '0;
    end else if (tick && (elapsed != EW'(MAX_TICKS))) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  // R10: the wait count only advances on a tick
  assert_count_on_tick_R10: assert property (@(posedge clk) disable iff (rst)
    (!clear && !tick) |=> $stable(elapsed))
    else $error("elapsed moved without a tick");
endmodule

// File: rtl/fps_step_ctrl.sv
module fps_step_ctrl
  import fps_pkg::*;
#(
  parameter int unsigned DLY_P2V = 200,
  parameter int unsigned DLY_V2D = 25,
  parameter int unsigned DLY_D2E = 0,
  parameter int unsigned DLY_E2B = 25,
  parameter int unsigned EW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          req,
  input  logic [EW-1:0] elapsed,
  output level_t        level_q,
  output level_t        level_d,
  output logic          step_go
);
  // Wait held at level k before the next step is DLY[k-1], for either direction,
  // except that leaving full-on, leaving level 1 downward and leaving off are immediate.
  localparam int unsigned DLY [4] = '{DLY_P2V, DLY_V2D, DLY_D2E, DLY_E2B};

  int unsigned need;
  logic        room;

  always_comb begin
    need = 0;
    if (req) begin
      if (level_q >= LV_PERIOD && level_q <= LV_VEE) need = DLY[int'(level_q) - 1];
    end else begin
      if (level_q >= LV_VDD && level_q <= LV_VEE) need = DLY[int'(level_q) - 1];
    end
    room    = req ? (level_q != LV_FULL) : (level_q != LV_OFF);
    step_go = !hold && room && (32'(elapsed) >= need);
    if (hold)         level_d = LV_OFF;
    else if (!step_go) level_d = level_q;
    else if (req)     level_d = level_q + 3'd1;
    else              level_d = level_q - 3'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) level_q <= LV_OFF;
    else     level_q <= level_d;
  end

  // R6: the level never moves by more than one step per cycle
  assert_single_step_R6: assert property (@(posedge clk) disable iff (rst)
    !hold |=> ((int'(level_q) - int'($past(level_q)) <= 1) &&
               (int'($past(level_q)) - int'(level_q) <= 1)))
    else $error("level skipped a step");

  // R6: with the request low the level never climbs
  assert_no_climb_when_low_R6: assert property (@(posedge clk) disable iff (rst)
    (!hold && !req) |=> (level_q <= $past(level_q)))
    else $error("level rose without a request");

  // R2: the level stays within the rail count
  assert_level_range_R2: assert property (@(posedge clk) disable iff (rst)
    level_q <= LV_FULL)
    else $error("level out of range");
endmodule

// File: rtl/fps_power_seq.sv
module fps_power_seq
  import fps_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned TICK_HZ = 1000,
  parameter int unsigned DLY_P2V = 200,
  parameter int unsigned DLY_V2D = 25,
  parameter int unsigned DLY_D2E = 0,
  parameter int unsigned DLY_E2B = 25
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_req,
  input  logic       direct_mode,
  input  logic [4:0] direct_en,
  output logic       period_en,
  output logic       vdd_en,
  output logic       data_en,
  output logic       vee_en,
  output logic       backlight_en,
  output logic       on_done,
  output logic       off_done
);
  localparam int unsigned MAX_AB = (DLY_P2V > DLY_V2D) ? DLY_P2V : DLY_V2D;
  localparam int unsigned MAX_CD = (DLY_D2E > DLY_E2B) ? DLY_D2E : DLY_E2B;
  localparam int unsigned MAXD   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int unsigned EW     = (MAXD < 1) ? 1 : $clog2(MAXD + 1);

  logic          tick;
  logic          step_go;
  logic          restart;
  logic [EW-1:0] elapsed;
  level_t        level_q;
  level_t        level_d;

  logic [RAIL_CNT-1:0] thermo_d;
  logic [RAIL_CNT-1:0] en_d;
  logic [RAIL_CNT-1:0] en_q;
  logic                mode_q;

  // Counters restart on every step and while held in direct mode.
  assign restart = step_go | direct_mode;

  fps_tick_gen #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_tick (
    .clk(clk), .rst(rst), .restart(restart), .tick(tick)
  );

  fps_dwell_timer #(.MAX_TICKS(MAXD), .EW(EW)) u_dwell (
    .clk(clk), .rst(rst), .clear(restart), .tick(tick), .elapsed(elapsed)
  );

  fps_step_ctrl #(
    .DLY_P2V(DLY_P2V), .DLY_V2D(DLY_V2D), .DLY_D2E(DLY_D2E), .DLY_E2B(DLY_E2B), .EW(EW)
  ) u_step (
    .clk(clk), .rst(rst), .hold(direct_mode), .req(pwr_req), .elapsed(elapsed),
    .level_q(level_q), .level_d(level_d), .step_go(step_go)
  );

  generate
    for (genvar gi = 0; gi < RAIL_CNT; gi++) begin : g_therm
      assign thermo_d[gi] = (level_d > level_t'(gi));
    end
  endgenerate

  assign en_d = direct_mode ? direct_en : thermo_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      mode_q   <= 1'b0;
      on_done  <= 1'b0;
      off_done <= 1'b1;
    end else begin
      en_q     <= en_d;
      mode_q   <= direct_mode;
      on_done  <= en_d[RAIL_BLIGHT];
      off_done <= !en_d[RAIL_PERIOD];
    end
  end

  assign period_en    = en_q[RAIL_PERIOD];
  assign vdd_en       = en_q[RAIL_VDD];
  assign data_en      = en_q[RAIL_DATA];
  assign vee_en       = en_q[RAIL_VEE];
  assign backlight_en = en_q[RAIL_BLIGHT];

  generate
    for (genvar gi = 1; gi < RAIL_CNT; gi++) begin : g_order_chk
      // R2: in hardware mode a rail is on only if its predecessor is on
      assert_rail_order_R2: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && en_q[gi]) |-> en_q[gi-1])
        else $error("rail order broken");
    end
  endgenerate

  // R7: in hardware mode fully-on and fully-off never coincide
  assert_status_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !mode_q |-> !(on_done && off_done))
    else $error("both status flags set");

  // R9: leaving direct mode restarts from the bottom of the sequence
  assert_exit_direct_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_q && !direct_mode) |=> (en_q[RAIL_CNT-1:1] == '0))
    else $error("exit from direct mode skipped the sequence");
endmodule

// File: tb/sim_fps_power_seq.sv
module sim_fps_power_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int D [4] = '{3, 1, 0, 2};

  logic clk = 1'b0;
  logic rst, pwr_req, direct_mode;
  logic [4:0] direct_en;
  logic period_en, vdd_en, data_en, vee_en, backlight_en, on_done, off_done;
  logic [4:0] rails;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  assign rails = {backlight_en, vee_en, data_en, vdd_en, period_en};

  always #(CLK_PERIOD/2) clk = ~clk;

  fps_power_seq #(
    .CLK_HZ(4000), .TICK_HZ(1000),
    .DLY_P2V(3), .DLY_V2D(1), .DLY_D2E(0), .DLY_E2B(2)
  ) u0 (
    .clk(clk), .rst(rst), .pwr_req(pwr_req), .direct_mode(direct_mode),
    .direct_en(direct_en), .period_en(period_en), .vdd_en(vdd_en),
    .data_en(data_en), .vee_en(vee_en), .backlight_en(backlight_en),
    .on_done(on_done), .off_done(off_done)
  );

  function automatic int up_gap(int k);
    return (k == 0) ? 1 : D[k-1] * DIV + 1;
  endfunction

  function automatic int dn_gap(int k);
    return (k == 5 || k == 1) ? 1 : D[k-1] * DIV + 1;
  endfunction

  function automatic logic [4:0] therm(int k);
    return 5'((1 << k) - 1);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_change(output int gap, output logic [4:0] v);
    logic [4:0] prev;
    prev = rails;
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (rails == prev && gap < 2000);
    v = rails;
  endtask

  task automatic step_check(int exp_gap, int exp_level, string tag);
    int g;
    logic [4:0] v;
    wait_change(g, v);
    check(g == exp_gap, tag, g, exp_gap);
    check(v == therm(exp_level), tag, int'(v), int'(therm(exp_level)));
  endtask

  task automatic climb(int from, int to, string tag);
    for (int k = from; k < to; k++)
      step_check(up_gap(k), k + 1, (k == 3) ? "R5 up" : tag);
  endtask

  task automatic descend(int from, int to, string tag);
    for (int k = from; k > to; k--)
      step_check(dn_gap(k), k - 1, (k == 3) ? "R5 down" : tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst = 1'b1; pwr_req = 1'b0; direct_mode = 1'b0; direct_en = '0;
    repeat (3) @(negedge clk);
    check(rails == 5'd0, "R1 enables in reset", int'(rails), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(rails == 5'd0, "R1 enables after reset", int'(rails), 0);
    check(off_done == 1'b1, "R1 off_done", int'(off_done), 1);
    check(on_done == 1'b0, "R1 on_done", int'(on_done), 0);

    // Full power-up then power-down
    pwr_req = 1'b1;
    climb(0, 5, "R3 R10 up");
    check(on_done == 1'b1, "R7 on_done at full", int'(on_done), 1);
    check(off_done == 1'b0, "R7 off_done at full", int'(off_done), 0);
    repeat (20) @(negedge clk);
    check(rails == 5'h1f, "R3 holds full on", int'(rails), 31);
    pwr_req = 1'b0;
    descend(5, 0, "R4 down");
    check(off_done == 1'b1, "R7 off_done at off", int'(off_done), 1);
    check(on_done == 1'b0, "R7 on_done at off", int'(on_done), 0);

    // Up then reverse at each intermediate level
    for (int k = 1; k <= 4; k++) begin
      pwr_req = 1'b1;
      climb(0, k, "R6 climb");
      pwr_req = 1'b0;
      descend(k, 0, "R6 reverse down");
    end

    // Down then reverse at each intermediate level
    for (int k = 4; k >= 1; k--) begin
      pwr_req = 1'b1;
      climb(0, 5, "R3 climb");
      pwr_req = 1'b0;
      descend(5, k, "R4 partial down");
      pwr_req = 1'b1;
      climb(k, 5, "R6 reverse up");
      pwr_req = 1'b0;
      descend(5, 0, "R4 down");
    end

    // Reversal in the middle of a wait at the supply level
    pwr_req = 1'b1;
    climb(0, 2, "R3 climb");
    repeat (2) @(negedge clk);
    check(rails == therm(2), "R6 mid-wait hold", int'(rails), int'(therm(2)));
    pwr_req = 1'b0;
    step_check(D[1] * DIV + 1 - 2, 1, "R6 mid-wait down");
    step_check(1, 0, "R6 mid-wait to off");

    // Reversal during the long wait at the period level
    pwr_req = 1'b1;
    climb(0, 1, "R3 climb");
    repeat (4) @(negedge clk);
    pwr_req = 1'b0;
    step_check(1, 0, "R6 leave period level");

    // Direct mode: all 32 patterns
    direct_mode = 1'b1;
    for (int p = 0; p < 32; p++) begin
      direct_en = 5'(p);
      @(negedge clk);
      check(rails == 5'(p), "R8 direct pattern", int'(rails), p);
      check(on_done == direct_en[4], "R7 direct on_done", int'(on_done), int'(direct_en[4]));
      check(off_done == !direct_en[0], "R7 direct off_done", int'(off_done), int'(!direct_en[0]));
    end
    direct_en = 5'b00100;
    pwr_req = 1'b1;
    repeat (30) @(negedge clk);
    check(rails == 5'b00100, "R8 request ignored", int'(rails), 4);
    pwr_req = 1'b0;
    repeat (5) @(negedge clk);
    check(rails == 5'b00100, "R8 request low ignored", int'(rails), 4);

    // Leave direct mode
    direct_mode = 1'b0;
    @(negedge clk);
    check(rails == 5'd0, "R9 exit to off", int'(rails), 0);
    check(off_done == 1'b1, "R9 off_done after exit", int'(off_done), 1);
    pwr_req = 1'b1;
    climb(0, 5, "R9 R10 fresh climb");
    pwr_req = 1'b0;
    descend(5, 0, "R4 down");

    finish_run();
  end
endmodule